// File: doc/BRIEF.md
# Floating-Point Add/Subtract Operand Aligner

This block sits in front of the mantissa adder of a single-precision floating-point add/subtract path. It takes two 32-bit operands and a subtract request, splits each operand into sign, exponent and fraction, and rebuilds the full significand (implicit leading one for normal values, zero for denormals). It then decides which operand has the larger magnitude, puts that one on the "large" lane, and shifts the other significand right by the exponent gap. Bits shifted past the 24-bit significand are kept as guard, round and sticky bits.

The same cycle also works out whether the adder must really add or subtract, given the requested operation and both signs. It also works out a provisional result sign and flags NaN, infinity and zero operands, so that the adder and rounding stages can act on special cases without decoding the operands again. All results are registered. They appear one clock after an input strobe, together with an output strobe, and they hold their value until the next strobe.

Top module: `fp_addsub_prenorm`

## Requirements
- R1: While `rst_n` is low and until the first accepted input, `outValid` and every data and flag output read 0.
- R2: `outValid` is high exactly one cycle after a cycle with `inValid` high. When `inValid` is low, no data or flag output changes.
- R3: Each 27-bit significand is {hidden, 23-bit fraction, 3'b000} before alignment. The hidden bit is 1 when the exponent field is nonzero. `expOut` is the larger operand's exponent field, or 1 when that field is 0.
- R4: The larger operand is the one with the greater value of bits [30:0]. On a tie, `opA` is taken as larger.
- R5: `sigSmall` is the smaller operand's 27-bit significand, shifted right by the difference of the effective exponents (a zero field counts as 1). Bit 2 is the guard bit and bit 1 is the round bit. Bit 0 is the OR of every bit shifted below it.
- R6: For a shift of 26 or more, bits [26:1] of `sigSmall` are 0 and bit 0 is 1 exactly when the smaller significand is nonzero.
- R7: `effSub` equals `subReq` XOR the sign of `opA` XOR the sign of `opB`.
- R8: `signOut` is the sign of `opA` when A is larger. Otherwise it is the sign of `opB` XOR `subReq`.
- R9: `snanIn` is set when either operand has an all-ones exponent, a nonzero fraction and fraction bit 22 clear. `qnanIn` is set when either operand has an all-ones exponent and fraction bit 22 set.
- R10: `infA`/`infB` mark an all-ones exponent with a zero fraction. `zeroA`/`zeroB` mark an all-zero exponent and fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands are presented this cycle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| subReq | input | 1 | 1 requests A minus B, 0 requests A plus B |
| outValid | output | 1 | Registered results are new this cycle |
| sigLarge | output | 27 | Significand of the larger operand with three zero low bits |
| sigSmall | output | 27 | Aligned significand of the smaller operand with guard, round, sticky |
| expOut | output | 8 | Common (larger) effective exponent |
| effSub | output | 1 | Mantissa unit must subtract |
| signOut | output | 1 | Provisional result sign |
| snanIn | output | 1 | An operand is a signalling NaN |
| qnanIn | output | 1 | An operand is a quiet NaN |
| infA | output | 1 | opA is infinite |
| infB | output | 1 | opB is infinite |
| zeroA | output | 1 | opA is zero |
| zeroB | output | 1 | opB is zero |

## Verification
The latency and hold properties assume that `inValid` is low during reset, so the first post-reset comparison sees no stale strobe. The bench drives `inValid` low throughout reset and changes inputs only on falling edges. The ordering and exponent-floor properties hold for any operand bits, so the stimulus mixes normals, denormals, zeros, infinities and both NaN kinds with no constraint. Exponent gaps from 0 to 128 cover the guard, round and sticky-only cases.

// File: rtl/fp_prenorm_pkg.sv
package fp_prenorm_pkg;
  // Strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic load;   // capture the current operands
    logic clear;  // drive all captured results to zero
  } prenormStrobe_t;
endpackage

// File: rtl/fp_prenorm_unpack.sv
module fp_prenorm_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRS_W  = 3,
  localparam int WORD_W  = 1 + EXP_W + FRAC_W,
  localparam int ALIGN_W = 1 + FRAC_W + GRS_W
) (
  input  logic [WORD_W-1:0]  word,
  output logic               sign,
  output logic [EXP_W-1:0]   expEff,
  output logic [ALIGN_W-1:0] sig,
  output logic [WORD_W-2:0]  mag,
  output logic               isSnan,
  output logic               isQnan,
  output logic               isInf,
  output logic               isZero
);
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] frac;
  logic expMax, expMin, fracNz;

  always_comb begin
    sign     = word[WORD_W-1];
    expField = word[WORD_W-2 -: EXP_W];
    frac     = word[FRAC_W-1:0];
    mag      = word[WORD_W-2:0];
    expMax   = &expField;
    expMin   = ~|expField;
    fracNz   = |frac;
    // Denormals and zero use an effective exponent of one.
    expEff   = expMin ? EXP_W'(1) : expField;
    sig      = {~expMin, frac, {GRS_W{1'b0}}};
    isQnan   = expMax & frac[FRAC_W-1];
    isSnan   = expMax & fracNz & ~frac[FRAC_W-1];
    isInf    = expMax & ~fracNz;
    isZero   = expMin & ~fracNz;
  end
endmodule

// File: rtl/fp_prenorm_align.sv
module fp_prenorm_align #(
  parameter int ALIGN_W = 27,
  parameter int AMT_W   = 8,
  localparam int CNT_W  = $clog2(ALIGN_W + 1),
  localparam int WIDE_W = 2 * ALIGN_W
) (
  input  logic [ALIGN_W-1:0] sigIn,
  input  logic [AMT_W-1:0]   shAmt,
  output logic [ALIGN_W-1:0] sigOut
);
  logic [CNT_W-1:0]  amt;
  logic [WIDE_W-1:0] stage [CNT_W+1];

  // Any gap at or past the full width behaves like a shift of the full width.
  assign amt = (shAmt >= AMT_W'(ALIGN_W)) ? CNT_W'(ALIGN_W) : shAmt[CNT_W-1:0];

  // The lower half of the wide vector catches every bit shifted out.
  assign stage[0] = {sigIn, {ALIGN_W{1'b0}}};

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    assign stage[s+1] = amt[s] ? (stage[s] >> (2 ** s)) : stage[s];
  end

  assign sigOut = {stage[CNT_W][WIDE_W-1:ALIGN_W+1],
                   stage[CNT_W][ALIGN_W] | (|stage[CNT_W][ALIGN_W-1:0])};
endmodule

// File: rtl/fp_prenorm_ctrl.sv
module fp_prenorm_ctrl
  import fp_prenorm_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inValid,
  output prenormStrobe_t strobes,
  output logic           outValid
);
  always_comb begin
    strobes.clear = ~rst_n;
    strobes.load  = rst_n & inValid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end
endmodule

// File: rtl/fp_prenorm_dp.sv
module fp_prenorm_dp
  import fp_prenorm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRS_W  = 3,
  localparam int WORD_W  = 1 + EXP_W + FRAC_W,
  localparam int ALIGN_W = 1 + FRAC_W + GRS_W
) (
  input  logic               clk,
  input  prenormStrobe_t     strobes,
  input  logic [WORD_W-1:0]  opA,
  input  logic [WORD_W-1:0]  opB,
  input  logic               subReq,
  output logic [ALIGN_W-1:0] sigLarge,
  output logic [ALIGN_W-1:0] sigSmall,
  output logic [EXP_W-1:0]   expOut,
  output logic               effSub,
  output logic               signOut,
  output logic               snanIn,
  output logic               qnanIn,
  output logic               infA,
  output logic               infB,
  output logic               zeroA,
  output logic               zeroB
);
  // Lane 0 is operand A, lane 1 is operand B.
  logic               uSign   [2];
  logic [EXP_W-1:0]   uExp    [2];
  logic [ALIGN_W-1:0] uSig    [2];
  logic [WORD_W-2:0]  uMag    [2];
  logic               uSnan   [2];
  logic               uQnan   [2];
  logic               uInf    [2];
  logic               uZero   [2];

  for (genvar i = 0; i < 2; i++) begin : g_unpack
    fp_prenorm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRS_W(GRS_W)) u_unpack (
      .word   ((i == 0) ? opA : opB),
      .sign   (uSign[i]),
      .expEff (uExp[i]),
      .sig    (uSig[i]),
      .mag    (uMag[i]),
      .isSnan (uSnan[i]),
      .isQnan (uQnan[i]),
      .isInf  (uInf[i]),
      .isZero (uZero[i])
    );
  end

  logic               swapB;
  logic [EXP_W-1:0]   expLarge, expGap;
  logic [ALIGN_W-1:0] sigBig, sigLittle, sigAligned;
  logic               effSubNext, signNext;

  always_comb begin
    // Ties stay on lane A so a subtract of equal values keeps A's sign.
    swapB      = uMag[1] > uMag[0];
    expLarge   = swapB ? uExp[1] : uExp[0];
    expGap     = swapB ? (uExp[1] - uExp[0]) : (uExp[0] - uExp[1]);
    sigBig     = swapB ? uSig[1] : uSig[0];
    sigLittle  = swapB ? uSig[0] : uSig[1];
    effSubNext = subReq ^ uSign[0] ^ uSign[1];
    signNext   = swapB ? (uSign[1] ^ subReq) : uSign[0];
  end

  fp_prenorm_align #(.ALIGN_W(ALIGN_W), .AMT_W(EXP_W)) u_align (
    .sigIn  (sigLittle),
    .shAmt  (expGap),
    .sigOut (sigAligned)
  );

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      sigLarge <= '0;
      sigSmall <= '0;
      expOut   <= '0;
      effSub   <= 1'b0;
      signOut  <= 1'b0;
      snanIn   <= 1'b0;
      qnanIn   <= 1'b0;
      infA     <= 1'b0;
      infB     <= 1'b0;
      zeroA    <= 1'b0;
      zeroB    <= 1'b0;
    end else if (strobes.load) begin
      sigLarge <= sigBig;
      sigSmall <= sigAligned;
      expOut   <= expLarge;
      effSub   <= effSubNext;
      signOut  <= signNext;
      snanIn   <= uSnan[0] | uSnan[1];
      qnanIn   <= uQnan[0] | uQnan[1];
      infA     <= uInf[0];
      infB     <= uInf[1];
      zeroA    <= uZero[0];
      zeroB    <= uZero[1];
    end
  end
endmodule

// File: rtl/fp_addsub_prenorm.sv
module fp_addsub_prenorm
  import fp_prenorm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRS_W  = 3,
  localparam int WORD_W  = 1 + EXP_W + FRAC_W,
  localparam int ALIGN_W = 1 + FRAC_W + GRS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic [WORD_W-1:0]  opA,
  input  logic [WORD_W-1:0]  opB,
  input  logic               subReq,
  output logic               outValid,
  output logic [ALIGN_W-1:0] sigLarge,
  output logic [ALIGN_W-1:0] sigSmall,
  output logic [EXP_W-1:0]   expOut,
  output logic               effSub,
  output logic               signOut,
  output logic               snanIn,
  output logic               qnanIn,
  output logic               infA,
  output logic               infB,
  output logic               zeroA,
  output logic               zeroB
);
  prenormStrobe_t strobes;

  fp_prenorm_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  fp_prenorm_dp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRS_W(GRS_W)) u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .subReq   (subReq),
    .sigLarge (sigLarge),
    .sigSmall (sigSmall),
    .expOut   (expOut),
    .effSub   (effSub),
    .signOut  (signOut),
    .snanIn   (snanIn),
    .qnanIn   (qnanIn),
    .infA     (infA),
    .infB     (infB),
    .zeroA    (zeroA),
    .zeroB    (zeroB)
  );
endmodule

// File: rtl/fp_prenorm_chk.sv
module fp_prenorm_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRS_W  = 3,
  localparam int WORD_W  = 1 + EXP_W + FRAC_W,
  localparam int ALIGN_W = 1 + FRAC_W + GRS_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inValid,
  input logic [WORD_W-1:0]  opA,
  input logic [WORD_W-1:0]  opB,
  input logic               subReq,
  input logic               outValid,
  input logic [ALIGN_W-1:0] sigLarge,
  input logic [ALIGN_W-1:0] sigSmall,
  input logic [EXP_W-1:0]   expOut,
  input logic               effSub,
  input logic               signOut,
  input logic               snanIn,
  input logic               qnanIn,
  input logic               infA,
  input logic               infB,
  input logic               zeroA,
  input logic               zeroB
);
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid == $past(inValid));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(inValid) |-> ($stable(sigLarge) && $stable(sigSmall) && $stable(expOut)
                         && $stable(effSub) && $stable(signOut)));

  p_large_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> sigLarge >= sigSmall);

  p_exp_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> expOut != '0);

  p_eff_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> effSub == ($past(subReq) ^ $past(opA[WORD_W-1]) ^ $past(opB[WORD_W-1])));

  p_nan_top_exp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && (snanIn || qnanIn)) |-> &expOut);

  p_inf_not_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !(infA && zeroA) && !(infB && zeroB));
endmodule

bind fp_addsub_prenorm fp_prenorm_chk u_chk (.*);

// File: tb/fp_addsub_prenorm_bench.sv
module fp_addsub_prenorm_bench;
  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        sub;
    logic [26:0] sL;
    logic [26:0] sS;
    logic [7:0]  ex;
    logic        es;
    logic        sg;
    logic [5:0]  fl;   // {snanIn, qnanIn, infA, infB, zeroA, zeroB}
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h3F800000, 32'h3F800000, 1'b0, 27'h4000000, 27'h4000000, 8'h7F, 1'b0, 1'b0, 6'h00},
    '{32'h3F800000, 32'h40000000, 1'b0, 27'h4000000, 27'h2000000, 8'h80, 1'b0, 1'b0, 6'h00},
    '{32'h3F800000, 32'h40000000, 1'b1, 27'h4000000, 27'h2000000, 8'h80, 1'b1, 1'b1, 6'h00},
    '{32'hBF800000, 32'h3F800000, 1'b0, 27'h4000000, 27'h4000000, 8'h7F, 1'b1, 1'b1, 6'h00},
    '{32'h3F800000, 32'h3FC00000, 1'b1, 27'h6000000, 27'h4000000, 8'h7F, 1'b1, 1'b1, 6'h00},
    '{32'h4B800000, 32'h3F800003, 1'b0, 27'h4000000, 27'h0000005, 8'h97, 1'b0, 1'b0, 6'h00},
    '{32'h4C000000, 32'h3F800000, 1'b0, 27'h4000000, 27'h0000002, 8'h98, 1'b0, 1'b0, 6'h00},
    '{32'h4C800000, 32'h3F800000, 1'b0, 27'h4000000, 27'h0000001, 8'h99, 1'b0, 1'b0, 6'h00},
    '{32'h4E800000, 32'h3F800000, 1'b0, 27'h4000000, 27'h0000001, 8'h9D, 1'b0, 1'b0, 6'h00},
    '{32'h00000001, 32'h00800000, 1'b0, 27'h4000000, 27'h0000008, 8'h01, 1'b0, 1'b0, 6'h00},
    '{32'h00000000, 32'h80000000, 1'b0, 27'h0000000, 27'h0000000, 8'h01, 1'b1, 1'b0, 6'h03},
    '{32'h7F800000, 32'h3F800000, 1'b0, 27'h4000000, 27'h0000001, 8'hFF, 1'b0, 1'b0, 6'h08},
    '{32'h7F800001, 32'h7FC00000, 1'b0, 27'h6000000, 27'h4000008, 8'hFF, 1'b0, 1'b0, 6'h30},
    '{32'hC0000000, 32'h3F800000, 1'b1, 27'h4000000, 27'h2000000, 8'h80, 1'b0, 1'b1, 6'h00},
    '{32'h3F800000, 32'hFF800000, 1'b1, 27'h4000000, 27'h0000001, 8'hFF, 1'b0, 1'b0, 6'h04}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        subReq = 1'b0;
  logic        outValid, effSub, signOut, snanIn, qnanIn, infA, infB, zeroA, zeroB;
  logic [26:0] sigLarge, sigSmall;
  logic [7:0]  expOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp_addsub_prenorm u_fp_addsub_prenorm (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opA(opA), .opB(opB), .subReq(subReq),
    .outValid(outValid), .sigLarge(sigLarge), .sigSmall(sigSmall), .expOut(expOut),
    .effSub(effSub), .signOut(signOut), .snanIn(snanIn), .qnanIn(qnanIn),
    .infA(infA), .infB(infB), .zeroA(zeroA), .zeroB(zeroB)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] flagsNow();
    return {snanIn, qnanIn, infA, infB, zeroA, zeroB};
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 outValid", 32'(outValid), 0);
    check("R1 sigLarge", 32'(sigLarge), 0);
    check("R1 sigSmall", 32'(sigSmall), 0);
    check("R1 expOut", 32'(expOut), 0);
    check("R1 flags", 32'(flagsNow()), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 32'(outValid), 0);

    for (int i = 0; i < NV; i++) begin
      opA = VECS[i].a;
      opB = VECS[i].b;
      subReq = VECS[i].sub;
      inValid = 1'b1;
      @(negedge clk);
      check($sformatf("R2 vec%0d outValid", i), 32'(outValid), 1);
      check($sformatf("R3/R4 vec%0d sigLarge", i), 32'(sigLarge), 32'(VECS[i].sL));
      check($sformatf("R5/R6 vec%0d sigSmall", i), 32'(sigSmall), 32'(VECS[i].sS));
      check($sformatf("R3 vec%0d expOut", i), 32'(expOut), 32'(VECS[i].ex));
      check($sformatf("R7 vec%0d effSub", i), 32'(effSub), 32'(VECS[i].es));
      check($sformatf("R8 vec%0d signOut", i), 32'(signOut), 32'(VECS[i].sg));
      check($sformatf("R9/R10 vec%0d flags", i), 32'(flagsNow()), 32'(VECS[i].fl));
    end

    // R2: operands change with the strobe low; results must hold.
    inValid = 1'b0;
    opA = 32'h3F800000;
    opB = 32'h7FC00000;
    subReq = 1'b0;
    @(negedge clk);
    check("R2 strobe drops", 32'(outValid), 0);
    @(negedge clk);
    check("R2 hold sigLarge", 32'(sigLarge), 32'h4000000);
    check("R2 hold sigSmall", 32'(sigSmall), 32'h1);
    check("R2 hold signOut", 32'(signOut), 0);
    check("R2 hold flags", 32'(flagsNow()), 32'h04);

    // R6: largest possible gap, smaller operand a denormal.
    opA = 32'h7F000000;
    opB = 32'h00000001;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R6 huge gap sigSmall", 32'(sigSmall), 32'h1);
    check("R3 huge gap expOut", 32'(expOut), 32'hFE);

    // R6: zero smaller operand leaves a clear sticky bit.
    opB = 32'h00000000;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R6 zero small sticky", 32'(sigSmall), 32'h0);
    check("R10 zeroB", 32'(flagsNow()), 32'h01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule